// File: doc/BRIEF.md
# Set-Associative Cache Victim Selector

This block keeps the replacement bookkeeping for every set of an N-way set-associative cache and names the way to overwrite when a miss has to bring a new line into a set. Tag compare, data storage and the refill itself are handled by the surrounding cache. The selector sees every lookup as one access cycle. Each access carries the set index, a hit flag, the way that hit, and the valid bits of that set.

In a hit cycle the selector only updates the recency state. In a miss cycle it drives the victim way combinationally in that same cycle. The filled way is then counted as the newest access. A parameter fixes the replacement scheme at build time. The schemes are exact LRU for two-way caches, a binary-tree approximation of LRU, plain round-robin, round-robin that steps over the most recently used way, and a pseudo-random pick.

Top module: `victim_selector`

## Requirements
- R1: In a miss cycle where `fill_valid` has any zero bit, `victim_way` is the lowest-numbered way whose bit is zero, under every policy. Such a fill does not move a round-robin pointer. It does count as an access to that way.
- R2: After reset, the first full-set miss in any set selects way 0 under every policy except random.
- R3: Exact LRU (policy POL_LRU, two ways only): on a full-set miss, the victim is the way that was not touched by the latest access to that set. Hits and fills both count as accesses.
- R4: Tree policy (POL_PLRU) keeps NUM_WAYS-1 node bits per set in a heap (root node 1, node k has children 2k and 2k+1, leaves NUM_WAYS..2*NUM_WAYS-1 are ways 0..NUM_WAYS-1). A node bit of 0 steers the victim walk to child 2k and a 1 steers it to 2k+1. On each access, every node on the path to the touched way is set to steer away from it.
- R5: Round-robin (POL_FIFO): each set keeps a pointer, starting at way 0. A full-set miss evicts the pointed way and advances the pointer by one, modulo NUM_WAYS. Hits leave the pointer alone.
- R6: Skip-recent round-robin (POL_NLRU): the candidate is the set's pointer. If the candidate equals the way touched by the latest access to that set, the victim is the next way instead. The pointer then moves to the victim plus one. Before any access to the set, nothing is skipped.
- R7: Random (POL_RAND): a 16-bit register resets to 0x0001. On every clock with reset released it shifts left, taking bit15^bit13^bit12^bit10 into bit 0. A full-set miss takes its low log2(NUM_WAYS) bits as the victim, whatever the access history.
- R8: An access to one set never changes the victim later chosen in any other set.
- R9: Cycles with `acc_valid` low leave all replacement state unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | $clog2(NUM_SETS) | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss needing a fill |
| acc_way | input | $clog2(NUM_WAYS) | Way that hit (ignored on a miss) |
| fill_valid | input | NUM_WAYS | Valid bits of the ways in the addressed set |
| victim_way | output | $clog2(NUM_WAYS) | Way to fill; meaningful in miss cycles |

## Verification
The bench drives five policy variants side by side and goes after the cases that are easy to get subtly wrong. The first is a hit immediately followed by a miss in the same set. A tree that updates the wrong node, or an LRU that ignores hits, would evict the line just used. The second is skip-recent round-robin when the pointer lands on the newest way. A selector that failed to skip would evict the hot line, and one that skipped without moving the pointer past the victim would repeat a victim. The third is a partially valid set. Choosing a policy victim there, or advancing the round-robin pointer, would shift every later eviction. Idle cycles carrying stray hit data, and traffic to neighbouring sets, are interleaved so that state leaking between sets or latched without a valid access shows up as a wrong later victim.

// File: rtl/vs_pkg.sv
// Shared policy type for the victim selector.
package vs_pkg;
    typedef enum logic [2:0] {
        POL_LRU  = 3'd0,
        POL_PLRU = 3'd1,
        POL_FIFO = 3'd2,
        POL_NLRU = 3'd3,
        POL_RAND = 3'd4
    } policy_e;
endpackage

// File: rtl/vs_plru_tree.sv
// Binary-tree recency logic for one set (combinational).
// Assumes NUM_WAYS is a power of two, at least 2. Node k lives at bits[k-1].
module vs_plru_tree #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-2:0] bits_i,
    input  logic [WAY_W-1:0]    touch_i,
    output logic [WAY_W-1:0]    victim_o,
    output logic [NUM_WAYS-2:0] bits_o
);
    logic [NUM_WAYS-1:0] pad_i;
    logic [NUM_WAYS-1:0] pad_o;
    logic [WAY_W:0]      node;
    logic [WAY_W:0]      leaf;
    logic [WAY_W:0]      parent;
    logic [WAY_W:0]      child;

    assign pad_i = {bits_i, 1'b0};
    assign leaf  = {1'b1, touch_i};

    // Walk from the root following node bits to find the victim leaf.
    always_comb begin
        node = {{WAY_W{1'b0}}, 1'b1};
        for (int l = 0; l < WAY_W; l++) begin
            node = {node[WAY_W-1:0], pad_i[node[WAY_W-1:0]]};
        end
        victim_o = node[WAY_W-1:0];
    end

    // Point every node on the touched way's path away from it.
    always_comb begin
        pad_o  = pad_i;
        parent = '0;
        child  = '0;
        for (int l = 0; l < WAY_W; l++) begin
            parent = leaf >> (WAY_W - l);
            child  = leaf >> (WAY_W - l - 1);
            pad_o[parent[WAY_W-1:0]] = ~child[0];
        end
        bits_o = pad_o[NUM_WAYS-1:1];
    end
endmodule

// File: rtl/vs_ring_pick.sv
// Round-robin victim pick with optional skip of the most recent way.
// Assumes NUM_WAYS is a power of two so pointer arithmetic wraps naturally.
module vs_ring_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             skip_en,
    input  logic [WAY_W-1:0] ptr_i,
    input  logic [WAY_W-1:0] mru_i,
    input  logic             mru_vld_i,
    output logic [WAY_W-1:0] victim_o,
    output logic [WAY_W-1:0] ptr_o
);
    // Take the pointer, stepping once past the recent way when enabled.
    always_comb begin
        victim_o = ptr_i;
        if (skip_en && mru_vld_i && (ptr_i == mru_i)) begin
            victim_o = ptr_i + 1'b1;
        end
        ptr_o = victim_o + 1'b1;
    end
endmodule

// File: rtl/vs_lfsr.sv
// Free-running 16-bit shift register for random victim choice.
// Assumes OUT_W <= 16; only the low OUT_W bits leave the module.
module vs_lfsr #(
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    logic [15:0] q;

    // Shift each cycle with taps 15,13,12,10; reset to a nonzero seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 16'h0001;
        end else begin
            q <= {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
        end
    end

    assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/victim_selector.sv
// Per-set replacement state and victim choice for an N-way cache.
// Assumes NUM_WAYS and NUM_SETS are powers of two; POL_LRU needs NUM_WAYS == 2.
// The victim is combinational in the miss cycle; state updates at the next edge.
module victim_selector #(
    parameter int              NUM_SETS = 64,
    parameter int              NUM_WAYS = 4,
    parameter vs_pkg::policy_e POLICY   = vs_pkg::POL_PLRU,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [SET_W-1:0]    acc_set,
    input  logic                acc_hit,
    input  logic [WAY_W-1:0]    acc_way,
    input  logic [NUM_WAYS-1:0] fill_valid,
    output logic [WAY_W-1:0]    victim_way
);
    import vs_pkg::*;

    logic             miss;
    logic             set_full;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] pol_way;
    logic [WAY_W-1:0] touch_way;

    assign miss      = acc_valid && !acc_hit;
    assign set_full  = &fill_valid;
    assign victim_way = set_full ? pol_way : inv_way;
    assign touch_way = acc_hit ? acc_way : victim_way;

    // Lowest way whose valid bit is clear.
    always_comb begin
        inv_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!fill_valid[w]) inv_way = WAY_W'(w);
        end
    end

    generate
        if (POLICY == POL_LRU || POLICY == POL_PLRU) begin : g_tree
            localparam int TW = NUM_WAYS - 1;
            logic [TW-1:0] tree_q [NUM_SETS];
            logic [TW-1:0] tree_nx;

            vs_plru_tree #(.NUM_WAYS(NUM_WAYS)) u_tree (
                .bits_i  (tree_q[acc_set]),
                .touch_i (touch_way),
                .victim_o(pol_way),
                .bits_o  (tree_nx)
            );

            // Store the updated tree of the addressed set on every access.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
                end else if (acc_valid) begin
                    tree_q[acc_set] <= tree_nx;
                end
            end
        end else if (POLICY == POL_FIFO || POLICY == POL_NLRU) begin : g_ring
            logic [WAY_W-1:0] ptr_q  [NUM_SETS];
            logic [WAY_W-1:0] mru_q  [NUM_SETS];
            logic             mvld_q [NUM_SETS];
            logic [WAY_W-1:0] ptr_nx;

            vs_ring_pick #(.NUM_WAYS(NUM_WAYS)) u_ring (
                .skip_en  (POLICY == POL_NLRU),
                .ptr_i    (ptr_q[acc_set]),
                .mru_i    (mru_q[acc_set]),
                .mru_vld_i(mvld_q[acc_set]),
                .victim_o (pol_way),
                .ptr_o    (ptr_nx)
            );

            // Record the newest way; advance the pointer on full-set misses only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_SETS; s++) begin
                        ptr_q[s]  <= '0;
                        mru_q[s]  <= '0;
                        mvld_q[s] <= 1'b0;
                    end
                end else if (acc_valid) begin
                    mru_q[acc_set]  <= touch_way;
                    mvld_q[acc_set] <= 1'b1;
                    if (miss && set_full) ptr_q[acc_set] <= ptr_nx;
                end
            end
        end else begin : g_rand
            vs_lfsr #(.OUT_W(WAY_W)) u_lfsr (
                .clk  (clk),
                .rst_n(rst_n),
                .rnd_o(pol_way)
            );
        end
    endgenerate
endmodule

// File: rtl/vs_checker.sv
// Temporal checks on the victim selector's ports, bound to every instance.
module vs_checker #(
    parameter int              NUM_SETS = 64,
    parameter int              NUM_WAYS = 4,
    parameter vs_pkg::policy_e POLICY   = vs_pkg::POL_PLRU,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic [SET_W-1:0]    acc_set,
    input logic                acc_hit,
    input logic [WAY_W-1:0]    acc_way,
    input logic [NUM_WAYS-1:0] fill_valid,
    input logic [WAY_W-1:0]    victim_way
);
    import vs_pkg::*;

    logic                seen;
    logic                full_miss;
    logic [NUM_WAYS-1:0] below;

    assign full_miss = acc_valid && !acc_hit && (&fill_valid);
    assign below     = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

    // Marks that the previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r1_lowest_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit && !(&fill_valid))
        |-> (!fill_valid[victim_way] && ((fill_valid & below) == below)));

    generate
        if (POLICY != POL_RAND) begin : g_det
            a_r2_first_victim_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (!seen && full_miss) |-> (victim_way == '0));
        end
        if (POLICY == POL_FIFO) begin : g_fifo
            a_r5_round_robin_step: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(full_miss) && full_miss && (acc_set == $past(acc_set)))
                |-> (victim_way == WAY_W'($past(victim_way) + 1'b1)));
        end
        if (POLICY == POL_LRU || POLICY == POL_PLRU || POLICY == POL_NLRU) begin : g_rec
            // R3, R4, R6: the way just hit is never the next victim of that set.
            a_r3_spare_recent_hit: assert property (@(posedge clk) disable iff (!rst_n)
                (seen && $past(acc_valid && acc_hit) && full_miss && (acc_set == $past(acc_set)))
                |-> (victim_way != $past(acc_way)));
        end
    endgenerate
endmodule

bind victim_selector vs_checker #(
    .NUM_SETS(NUM_SETS),
    .NUM_WAYS(NUM_WAYS),
    .POLICY  (POLICY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_set   (acc_set),
    .acc_hit   (acc_hit),
    .acc_way   (acc_way),
    .fill_valid(fill_valid),
    .victim_way(victim_way)
);

// File: tb/sim_victim_selector.sv
// Runs five policy variants on one access stream against behavioural models.
module sim_victim_selector;
    import vs_pkg::*;

    localparam int SETS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_way = '0;
    logic [3:0] fill_valid = 4'hF;
    logic [1:0] v_plru, v_fifo, v_nlru, v_rand;
    logic       v_lru;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 0;
    string tag   = "";

    always #4 clk = ~clk;

    victim_selector #(.NUM_SETS(SETS), .NUM_WAYS(4), .POLICY(POL_PLRU)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill_valid(fill_valid), .victim_way(v_plru));
    victim_selector #(.NUM_SETS(SETS), .NUM_WAYS(2), .POLICY(POL_LRU)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way[0]), .fill_valid(fill_valid[1:0]), .victim_way(v_lru));
    victim_selector #(.NUM_SETS(SETS), .NUM_WAYS(4), .POLICY(POL_FIFO)) u2 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill_valid(fill_valid), .victim_way(v_fifo));
    victim_selector #(.NUM_SETS(SETS), .NUM_WAYS(4), .POLICY(POL_NLRU)) u3 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill_valid(fill_valid), .victim_way(v_nlru));
    victim_selector #(.NUM_SETS(SETS), .NUM_WAYS(4), .POLICY(POL_RAND)) u4 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_way(acc_way), .fill_valid(fill_valid), .victim_way(v_rand));

    // Behavioural models
    int lru_old [SETS];          // way touched least recently (2-way)
    int tree    [SETS][4];       // node bits, index 1..3
    int fptr    [SETS];
    int nptr    [SETS];
    int nmru    [SETS];
    bit nmvld   [SETS];
    logic [15:0] lf;

    // R7 model of the random source.
    always @(posedge clk) begin
        if (!rst_n) lf <= 16'h0001;
        else        lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            lru_old[s] = 0; fptr[s] = 0; nptr[s] = 0; nmru[s] = 0; nmvld[s] = 0;
            for (int k = 0; k < 4; k++) tree[s][k] = 0;
        end
    endtask

    function automatic int first_zero(input int mask, input int n);
        for (int w = 0; w < n; w++) if (((mask >> w) & 1) == 0) return w;
        return -1;
    endfunction

    function automatic int tree_pick(input int s);
        int lo = 0, span = 4, node = 1;
        while (span > 1) begin
            span = span / 2;
            if (tree[s][node] == 1) begin lo = lo + span; node = 2 * node + 1; end
            else node = 2 * node;
        end
        return lo;
    endfunction

    task automatic tree_touch(input int s, input int w);
        int lo = 0, span = 4, node = 1;
        while (span > 1) begin
            span = span / 2;
            if (w >= lo + span) begin tree[s][node] = 0; lo = lo + span; node = 2 * node + 1; end
            else begin tree[s][node] = 1; node = 2 * node; end
        end
    endtask

    task automatic check(input string req, input int inst, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s u%0d victim got %0d expected %0d at %0t", req, inst, got, exp, $time);
        end
    endtask

    task automatic step(input bit v, input int s, input bit h, input int w, input int m);
        int e0, e1, e2, e3, e4, t0, t1, t3, n3;
        bit full4, full2;
        string r;
        @(negedge clk);
        acc_valid = v; acc_set = 3'(s); acc_hit = h; acc_way = 2'(w); fill_valid = 4'(m);
        #2;
        full4 = (m & 15) == 15;
        full2 = (m & 3) == 3;
        e0 = full4 ? tree_pick(s) : first_zero(m, 4);
        e1 = full2 ? lru_old[s] : first_zero(m, 2);
        e2 = full4 ? fptr[s] : first_zero(m, 4);
        n3 = (nmvld[s] && nmru[s] == nptr[s]) ? (nptr[s] + 1) % 4 : nptr[s];
        e3 = full4 ? n3 : first_zero(m, 4);
        e4 = full4 ? int'(lf[1:0]) : first_zero(m, 4);
        if (v && !h) begin
            r = (tag != "") ? tag : "";
            check(full4 ? (r != "" ? r : "R4") : "R1", 0, int'(v_plru), e0);
            check(full2 ? (r != "" ? r : "R3") : "R1", 1, int'(v_lru), e1);
            check(full4 ? (r != "" ? r : "R5") : "R1", 2, int'(v_fifo), e2);
            check(full4 ? (r != "" ? r : "R6") : "R1", 3, int'(v_nlru), e3);
            check(full4 ? "R7" : "R1", 4, int'(v_rand), e4);
        end
        if (v) begin
            t0 = h ? w : e0;
            t1 = h ? (w % 2) : e1;
            t3 = h ? w : e3;
            tree_touch(s, t0);
            lru_old[s] = 1 - t1;
            if (!h && full4) begin
                fptr[s] = (fptr[s] + 1) % 4;
                nptr[s] = (n3 + 1) % 4;
            end
            nmru[s] = t3; nmvld[s] = 1;
        end
    endtask

    task automatic end_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        end_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: first full-set miss after reset picks way 0.
        tag = "R2";
        step(1, 3, 0, 0, 15);
        step(1, 6, 0, 0, 15);
        // R9: idle cycles carrying hit data must not touch state.
        tag = "R9";
        step(0, 3, 1, 1, 15);
        step(0, 3, 0, 2, 15);
        step(1, 3, 0, 0, 15);
        // R8: traffic in set 1 leaves set 2 untouched.
        tag = "R8";
        step(1, 1, 1, 0, 15);
        step(1, 1, 0, 0, 15);
        step(1, 2, 0, 0, 15);
        // R1: partially valid sets.
        tag = "";
        step(1, 4, 0, 0, 4'b1011);
        step(1, 4, 0, 0, 4'b0000);
        step(1, 4, 0, 0, 15);
        // R6 / R3 / R4: hit then miss in the same set.
        step(1, 5, 1, 0, 15);
        step(1, 5, 0, 0, 15);
        step(1, 5, 1, 2, 15);
        step(1, 5, 0, 0, 15);
        // R5: run of full-set misses wraps the pointer.
        for (int i = 0; i < 6; i++) step(1, 7, 0, 0, 15);
        // Mixed traffic.
        for (int i = 0; i < 4000; i++) begin
            int m;
            m = ($urandom % 6 == 0) ? int'($urandom % 16) : 15;
            step(($urandom % 8) != 0, int'($urandom % 3), ($urandom % 2) == 1,
                 int'($urandom % 4), m);
        end
        end_run();
    end
endmodule